// File: doc/BRIEF.md
# Serial Codec Control-Register Port

This block is the control side of a two-channel codec that sits on a frame-synchronised serial bus. The host sends 16-bit command words on the serial input. A frame-sync pulse marks the first word of a frame, and the following words follow back to back. Each word lands in a time slot counted from the frame start. The device owns `N_CH` consecutive slots starting at `DEV_SLOT`, one per channel, and each owned slot addresses the register bank of its own channel.

A command word either writes a byte into a register or reads one back. Read data is returned in the lower half of the same word. Writes are first held in a staged copy of the bank and become active only at the next frame sync. Writes flagged as broadcast are accepted in any slot, so every cascaded device on the bus can be loaded in one frame. Bits that steer resources shared by both channels are kept identical in the two banks.

A mode bit switches the port from command decoding to continuous data transfer. In that mode words are no longer decoded. The port returns to command mode through an in-band escape when the split word format is selected, or through reset.

Top module: `codec_ctl_port`

## Requirements
- R1: A word starts on the rising edge where `fsync` is sampled high and takes 16 rising edges, MSB first. Further words follow without gaps. The word after `fsync` is slot 0, and slot `DEV_SLOT+c` belongs to channel `c`.
- R2: A word with bits 15:13 = address, bit 12 = 0 and bit 11 = 0, sent in the slot of channel `c`, loads bits 7:0 into register `address` of channel `c`. `reg_view` (byte at bit `((c*6)+address-1)*8`) shows the new value only after the next `fsync` edge.
- R3: When two writes hit the same register before a frame sync, the later one is the value that is committed.
- R4: A word with bit 12 = 1 in an owned slot drives the active register byte on `sdout` during bits 7:0 of that same word, MSB first. `sdout` is 0 during bits 15:8. The lower byte of the read word changes nothing.
- R5: Addresses 1 to 6 are implemented. Writes to addresses 0 and 7 are dropped, and reads of them return 0x00.
- R6: Register 1 bits 6 and 0 (mask 0x41) and register 4 bits 7:4 (mask 0xF0) are shared. A write to either channel also updates these bits in the other channel.
- R7: A write with bit 11 = 1 is accepted in every slot of the frame, including slots the device does not own, and loads the value into the addressed register of all channels.
- R8: A word without bit 11 in a slot the device does not own changes no register, and `sdout` stays 0 for that word.
- R9: Reset clears `sdout` and puts the port in command mode. Register 1 resets to 0x00, and register `a` (a = 2..6) resets to `0x08 | a` in both channels.
- R10: While the active register 1 bit 6 is set, `stream_mode` is 1, no word is decoded as a read or a write, and `sdout` stays 0.
- R11: In stream mode with active register 1 bit 0 set, an owned-slot word whose bit 0 is 1 clears register 1 bit 6 in both banks, effective at the next frame sync. With bit 0 of register 1 clear, such words have no effect.
- R12: `sdout` changes only on falling edges of `bclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, high for the first bit of a frame |
| sdin | input | 1 | Serial command input, sampled on rising edges |
| sdout | output | 1 | Serial read-data output, updated on falling edges |
| stream_mode | output | 1 | 1 while continuous data-transfer mode is active |
| reg_view | output | N_CH*6*8 | Active register bytes of all channels |

## Verification
The bench builds the port with four slots per frame and the device placed at slot 1. This leaves one foreign slot in front of the owned pair and one behind it, so both foreign positions are exercised for broadcast and non-broadcast words. With two channels, every address 0 to 7 of every channel is written and then read back. A bench model of the staged and active banks predicts each read byte and each committed value. The frame-sync delay, the shared-bit mirroring and both ways in and out of stream mode can all be observed at the ports.

// File: rtl/codec_ctl_pkg.sv
`timescale 1ns/1ps
package codec_ctl_pkg;

  localparam int unsigned WORD_W      = 16;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned REGS_PER_CH = 6;
  localparam int unsigned MODE_BIT    = 6;
  localparam int unsigned FMT_BIT     = 0;
  localparam logic [ADDR_W-1:0] MODE_REG = 3'd1;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // addresses 1..6 hold storage, 0 and 7 are empty
  function automatic logic addr_valid(input addr_t a);
    return (a != 3'd0) && (a != 3'd7);
  endfunction

  // bits steering resources common to every channel
  function automatic byte_t share_mask(input addr_t a);
    case (a)
      3'd1:    return 8'h41;
      3'd4:    return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic byte_t reset_value(input addr_t a);
    return (a == MODE_REG) ? 8'h00 : (8'h08 | {5'b0, a});
  endfunction

  // a write aimed at another channel only carries the shared bits
  function automatic byte_t merge_shared(input byte_t old_v, input byte_t nv, input addr_t a);
    byte_t m;
    m = share_mask(a);
    return (old_v & ~m) | (nv & m);
  endfunction

  function automatic byte_t clear_mode(input byte_t v);
    return v & ~(byte_t'(1) << MODE_BIT);
  endfunction

endpackage

// File: rtl/codec_ctl_shifter.sv
`timescale 1ns/1ps
module codec_ctl_shifter
  import codec_ctl_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned SLOT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              din,
  output logic [4:0]        bit_cnt,
  output logic [SLOT_W-1:0] slot,
  output addr_t             hdr_addr,
  output logic              hdr_rd,
  output logic              word_done,
  output addr_t             w_addr,
  output logic              w_rd,
  output logic              w_bcast,
  output byte_t             w_data
);

  localparam logic [4:0] LAST_BIT = 5'(WORD_W - 1);
  localparam logic [4:0] FULL     = 5'(WORD_W);
  localparam logic [4:0] HDR_AT   = 5'(BYTE_W - 1);
  localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(NUM_SLOTS);

  logic [WORD_W-2:0] sreg;
  logic [WORD_W-1:0] full_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      slot     <= IDLE_SLOT;
      sreg     <= '0;
      hdr_addr <= '0;
      hdr_rd   <= 1'b0;
    end else if (fsync) begin
      bit_cnt <= 5'd1;
      slot    <= '0;
      sreg    <= {{(WORD_W-2){1'b0}}, din};
    end else if (bit_cnt == FULL) begin
      bit_cnt <= 5'd1;
      if (slot != IDLE_SLOT) slot <= slot + SLOT_W'(1);
      sreg    <= {{(WORD_W-2){1'b0}}, din};
    end else if (bit_cnt != 5'd0) begin
      bit_cnt <= bit_cnt + 5'd1;
      sreg    <= {sreg[WORD_W-3:0], din};
      if (bit_cnt == HDR_AT) begin
        hdr_addr <= sreg[6:4];
        hdr_rd   <= sreg[3];
      end
    end
  end

  assign full_word = {sreg, din};
  assign word_done = !fsync && (bit_cnt == LAST_BIT);
  assign w_addr    = full_word[15:13];
  assign w_rd      = full_word[12];
  assign w_bcast   = full_word[11];
  assign w_data    = full_word[7:0];

  p_fsync_starts_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (bit_cnt == 5'd1) && (slot == '0));

  p_word_length_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (bit_cnt == FULL));

endmodule

// File: rtl/codec_ctl_decoder.sv
`timescale 1ns/1ps
module codec_ctl_decoder
  import codec_ctl_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned DEV_SLOT  = 0,
  parameter int unsigned N_CH      = 2,
  parameter int unsigned SLOT_W    = 2,
  parameter int unsigned CH_W      = 1
) (
  input  logic              word_done,
  input  logic [SLOT_W-1:0] slot,
  input  addr_t             w_addr,
  input  logic              w_rd,
  input  logic              w_bcast,
  input  byte_t             w_data,
  input  logic              stream_mode,
  input  logic              fmt_split,
  output logic              own_slot,
  output logic [CH_W-1:0]   slot_ch,
  output logic              wr_evt,
  output logic              wr_all,
  output logic              drop_evt,
  output logic              rd_evt,
  output logic              esc_evt
);

  localparam logic [31:0] OWN_LO = 32'(DEV_SLOT);
  localparam logic [31:0] OWN_HI = 32'(DEV_SLOT + N_CH);

  logic in_frame;
  logic ctl_cycle;
  logic wr_target;

  assign in_frame  = slot < SLOT_W'(NUM_SLOTS);
  assign own_slot  = (32'(slot) >= OWN_LO) && (32'(slot) < OWN_HI);
  assign slot_ch   = CH_W'(32'(slot) - OWN_LO);

  // command decoding only outside stream mode
  assign ctl_cycle = word_done && !stream_mode && in_frame;
  assign wr_target = ctl_cycle && !w_rd && (own_slot || w_bcast);
  assign wr_evt    = wr_target && addr_valid(w_addr);
  assign drop_evt  = wr_target && !addr_valid(w_addr);
  assign wr_all    = w_bcast;
  assign rd_evt    = ctl_cycle && own_slot && w_rd;
  assign esc_evt   = word_done && stream_mode && fmt_split && own_slot && w_data[0];

  always_comb begin
    assert ($onehot0({wr_evt, drop_evt, rd_evt, esc_evt}));
  end

endmodule

// File: rtl/codec_ctl_regbank.sv
`timescale 1ns/1ps
module codec_ctl_regbank
  import codec_ctl_pkg::*;
#(
  parameter int unsigned N_CH = 2,
  parameter int unsigned CH_W = 1,
  parameter int unsigned BANK_W = N_CH * REGS_PER_CH * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              wr_evt,
  input  logic              wr_all,
  input  logic [CH_W-1:0]   wr_ch,
  input  addr_t             wr_addr,
  input  byte_t             wr_data,
  input  logic              esc_evt,
  input  logic              drop_evt,
  input  logic              rd_evt,
  input  logic [CH_W-1:0]   rd_ch,
  input  addr_t             rd_addr,
  output byte_t             rd_data,
  output logic [BANK_W-1:0] act_flat,
  output logic              stream_mode,
  output logic              fmt_split
);

  localparam int unsigned CH_STRIDE = REGS_PER_CH * BYTE_W;

  logic [BANK_W-1:0] pend_flat;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    for (genvar r = 0; r < REGS_PER_CH; r++) begin : g_reg
      localparam addr_t ADDR = addr_t'(r + 1);
      localparam int unsigned LSB = (c * REGS_PER_CH + r) * BYTE_W;

      byte_t pend_q;
      byte_t act_q;
      logic  hit;
      logic  direct;

      assign hit    = wr_evt && (wr_addr == ADDR);
      assign direct = wr_all || (wr_ch == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= reset_value(ADDR);
          act_q  <= reset_value(ADDR);
        end else begin
          if (fsync) act_q <= pend_q;
          if (esc_evt && (ADDR == MODE_REG)) pend_q <= clear_mode(pend_q);
          else if (hit) pend_q <= direct ? wr_data : merge_shared(pend_q, wr_data, ADDR);
        end
      end

      assign pend_flat[LSB +: BYTE_W] = pend_q;
      assign act_flat[LSB +: BYTE_W]  = act_q;
    end

    p_escape_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      esc_evt |=> !pend_flat[c*CH_STRIDE + MODE_BIT]);

    if (c > 0) begin : g_mirror
      p_shared_reg1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_flat[c*CH_STRIDE +: BYTE_W] & share_mask(3'd1)) ==
        (pend_flat[0 +: BYTE_W] & share_mask(3'd1)));
      p_shared_reg4_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_flat[c*CH_STRIDE + 3*BYTE_W +: BYTE_W] & share_mask(3'd4)) ==
        (pend_flat[3*BYTE_W +: BYTE_W] & share_mask(3'd4)));
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < N_CH; c++) begin
      for (int r = 0; r < REGS_PER_CH; r++) begin
        if ((rd_ch == CH_W'(c)) && (rd_addr == addr_t'(r + 1)))
          rd_data = act_flat[(c * REGS_PER_CH + r) * BYTE_W +: BYTE_W];
      end
    end
  end

  // channel 0 register 1 governs the mode; its bits are shared
  assign stream_mode = act_flat[MODE_BIT];
  assign fmt_split   = act_flat[FMT_BIT];

  p_commit_on_fsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync |=> $stable(act_flat));

  p_read_keeps_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> $stable(pend_flat));

  p_unimpl_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(pend_flat));

endmodule

// File: rtl/codec_ctl_dout.sv
`timescale 1ns/1ps
module codec_ctl_dout
  import codec_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] bit_cnt,
  input  logic       hdr_rd,
  input  addr_t      hdr_addr,
  input  logic       own_slot,
  input  logic       stream_mode,
  input  byte_t      rd_data,
  output logic       dout
);

  logic       in_lower;
  logic       send;
  logic [2:0] pos;

  // after bit k of the word has been sampled, drive the bit of position 15-k
  assign in_lower = (bit_cnt >= 5'(BYTE_W)) && (bit_cnt <= 5'(WORD_W - 1));
  assign pos      = 3'd7 - bit_cnt[2:0];
  assign send     = in_lower && hdr_rd && own_slot && !stream_mode && addr_valid(hdr_addr);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= send ? rd_data[pos] : 1'b0;
  end

  p_upper_byte_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bit_cnt < 5'(BYTE_W)) || (bit_cnt == 5'(WORD_W))) |-> !dout);

  p_foreign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !own_slot |-> !dout);

  p_stream_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stream_mode |-> !dout);

endmodule

// File: rtl/codec_ctl_port.sv
`timescale 1ns/1ps
module codec_ctl_port
  import codec_ctl_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned DEV_SLOT  = 0,
  parameter int unsigned N_CH      = 2
) (
  input  logic                               bclk,
  input  logic                               rst_n,
  input  logic                               fsync,
  input  logic                               sdin,
  output logic                               sdout,
  output logic                               stream_mode,
  output logic [N_CH*REGS_PER_CH*BYTE_W-1:0] reg_view
);

  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS + 1);
  localparam int unsigned CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [4:0]        bit_cnt;
  logic [SLOT_W-1:0] slot;
  addr_t             hdr_addr;
  logic              hdr_rd;
  logic              word_done;
  addr_t             w_addr;
  logic              w_rd;
  logic              w_bcast;
  byte_t             w_data;
  logic              own_slot;
  logic [CH_W-1:0]   slot_ch;
  logic              wr_evt;
  logic              wr_all;
  logic              drop_evt;
  logic              rd_evt;
  logic              esc_evt;
  logic              fmt_split;
  byte_t             rd_data;

  codec_ctl_shifter #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_shift (
    .clk(bclk), .rst_n(rst_n), .fsync(fsync), .din(sdin),
    .bit_cnt(bit_cnt), .slot(slot), .hdr_addr(hdr_addr), .hdr_rd(hdr_rd),
    .word_done(word_done), .w_addr(w_addr), .w_rd(w_rd), .w_bcast(w_bcast),
    .w_data(w_data)
  );

  codec_ctl_decoder #(
    .NUM_SLOTS(NUM_SLOTS), .DEV_SLOT(DEV_SLOT), .N_CH(N_CH),
    .SLOT_W(SLOT_W), .CH_W(CH_W)
  ) u_dec (
    .word_done(word_done), .slot(slot), .w_addr(w_addr), .w_rd(w_rd),
    .w_bcast(w_bcast), .w_data(w_data), .stream_mode(stream_mode),
    .fmt_split(fmt_split), .own_slot(own_slot), .slot_ch(slot_ch),
    .wr_evt(wr_evt), .wr_all(wr_all), .drop_evt(drop_evt), .rd_evt(rd_evt),
    .esc_evt(esc_evt)
  );

  codec_ctl_regbank #(.N_CH(N_CH), .CH_W(CH_W)) u_bank (
    .clk(bclk), .rst_n(rst_n), .fsync(fsync),
    .wr_evt(wr_evt), .wr_all(wr_all), .wr_ch(slot_ch), .wr_addr(w_addr),
    .wr_data(w_data), .esc_evt(esc_evt), .drop_evt(drop_evt), .rd_evt(rd_evt),
    .rd_ch(slot_ch), .rd_addr(hdr_addr), .rd_data(rd_data),
    .act_flat(reg_view), .stream_mode(stream_mode), .fmt_split(fmt_split)
  );

  codec_ctl_dout u_dout (
    .clk(bclk), .rst_n(rst_n), .bit_cnt(bit_cnt), .hdr_rd(hdr_rd),
    .hdr_addr(hdr_addr), .own_slot(own_slot), .stream_mode(stream_mode),
    .rd_data(rd_data), .dout(sdout)
  );

endmodule

// File: tb/tb_codec_ctl_port.sv
`timescale 1ns/1ps
module tb_codec_ctl_port;

  localparam int NS = 4;
  localparam int DS = 1;
  localparam int NC = 2;
  localparam int NR = 6;
  localparam logic [15:0] IDLE = 16'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic din = 1'b0;
  logic dout;
  logic stream_mode;
  logic [NC*NR*8-1:0] reg_view;

  always #2 clk = ~clk;

  codec_ctl_port #(.NUM_SLOTS(NS), .DEV_SLOT(DS), .N_CH(NC)) dut (
    .bclk(clk), .rst_n(rst_n), .fsync(fsync), .sdin(din),
    .sdout(dout), .stream_mode(stream_mode), .reg_view(reg_view)
  );

  int checks = 0;
  int fails = 0;
  int r12_bad = 0;
  logic r12_v;
  logic [7:0] m_act [NC][8];
  logic [7:0] m_pend[NC][8];

  // R12: sdout must hold across every rising edge
  always @(posedge clk) begin
    r12_v = dout;
    #1;
    if (dout !== r12_v) r12_bad++;
  end

  function automatic logic [7:0] b_mask(input int a);
    if (a == 1) return 8'b0100_0001;
    if (a == 4) return 8'b1111_0000;
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_rst(input int a);
    return (a == 1) ? 8'h00 : 8'(8 + a);
  endfunction

  function automatic logic [15:0] mkw(input int a, input bit rd, input bit bc, input logic [7:0] d);
    return {3'(a), rd, bc, 3'b000, d};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic m_reset();
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 8; a++) begin
        m_act[c][a]  = b_rst(a);
        m_pend[c][a] = b_rst(a);
      end
  endtask

  task automatic check_state(input string req);
    for (int c = 0; c < NC; c++)
      for (int a = 1; a <= NR; a++)
        check(req, 32'(reg_view[((c*NR)+a-1)*8 +: 8]), 32'(m_act[c][a]));
    check({req, " stream_mode"}, 32'(stream_mode), 32'(m_act[0][1][6]));
  endtask

  task automatic run_frame(input string req, input logic [15:0] w0, input logic [15:0] w1,
                           input logic [15:0] w2, input logic [15:0] w3);
    logic [15:0] w[NS];
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 8; a++) m_act[c][a] = m_pend[c][a];
    for (int s = 0; s < NS; s++) begin
      logic [15:0] got;
      logic [15:0] expd;
      bit own, rd, bc, cont, fmt, valid;
      int ch, a;
      logic [7:0] d;
      own = (s >= DS) && (s < DS + NC);
      ch = s - DS;
      a = int'(w[s][15:13]);
      rd = w[s][12];
      bc = w[s][11];
      d = w[s][7:0];
      cont = m_act[0][1][6];
      fmt = m_act[0][1][0];
      valid = (a >= 1) && (a <= NR);
      expd = (!cont && own && rd && valid) ? {8'h00, m_act[ch][a]} : 16'h0000;
      for (int b = 15; b >= 0; b--) begin
        @(negedge clk);
        fsync = (s == 0) && (b == 15);
        din = w[s][b];
        #1 got[b] = dout;
      end
      check({req, " sdout slot"}, 32'(got), 32'(expd));
      if (cont) begin
        if (own && fmt && w[s][0])
          for (int c = 0; c < NC; c++) m_pend[c][1][6] = 1'b0;
      end else if (!rd && (own || bc) && valid) begin
        for (int c = 0; c < NC; c++) begin
          if (bc || c == ch) m_pend[c][a] = d;
          else m_pend[c][a] = (m_pend[c][a] & ~b_mask(a)) | (d & b_mask(a));
        end
      end
    end
    @(negedge clk);
    fsync = 1'b0;
    din = 1'b0;
    #1 check_state(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fsync = 1'b0;
    din = 1'b0;
    repeat (3) @(negedge clk);
    m_reset();
    #1 check("R9 sdout in reset", 32'(dout), 32'h0);
    check_state("R9 reset values");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] ww[NS];
    do_reset();

    // R2/R5 write every address of every channel, R4 read back with junk low byte
    for (int ch = 0; ch < NC; ch++) begin
      for (int a = 0; a < 8; a++) begin
        logic [7:0] d;
        d = 8'(a * 17) ^ ((ch == 0) ? 8'hA5 : 8'h5A);
        if (a == 1) d = d & 8'hBE;
        for (int s = 0; s < NS; s++) ww[s] = IDLE;
        ww[DS+ch] = mkw(a, 1'b0, 1'b0, d);
        run_frame("R2/R5 write sweep", ww[0], ww[1], ww[2], ww[3]);
        for (int s = 0; s < NS; s++) ww[s] = IDLE;
        ww[DS]   = mkw(a, 1'b1, 1'b0, 8'hFF);
        ww[DS+1] = mkw(a, 1'b1, 1'b0, 8'hFF);
        run_frame("R4/R5/R1 read back", ww[0], ww[1], ww[2], ww[3]);
      end
    end

    // R7 broadcast in both foreign slots
    run_frame("R7 broadcast", mkw(3, 0, 1, 8'hA5), IDLE, IDLE, mkw(5, 0, 1, 8'h5A));
    run_frame("R7 read", IDLE, mkw(3, 1, 0, 8'h00), mkw(5, 1, 0, 8'h00), IDLE);

    // R8 foreign plain write and read
    run_frame("R8 foreign", mkw(2, 0, 0, 8'h77), IDLE, IDLE, mkw(6, 1, 0, 8'h00));
    run_frame("R8 after", IDLE, mkw(2, 1, 0, 8'h00), mkw(6, 1, 0, 8'h00), IDLE);

    // R3 later write wins, R6 shared upper nibble of register 4
    run_frame("R3/R6 overwrite", mkw(2, 0, 1, 8'h11), mkw(2, 0, 0, 8'h22), mkw(4, 0, 0, 8'hC3), IDLE);
    run_frame("R3/R6 read", IDLE, mkw(4, 1, 0, 8'h00), mkw(2, 1, 0, 8'h00), IDLE);

    // R6 shared format bit from channel 1
    run_frame("R6 shared reg1", IDLE, IDLE, mkw(1, 0, 0, 8'h01), IDLE);
    run_frame("R6 read", IDLE, mkw(1, 1, 0, 8'h00), IDLE, IDLE);

    // R10 enter stream mode, R11 escape with split format
    run_frame("R10 enter", IDLE, mkw(1, 0, 0, 8'h41), IDLE, IDLE);
    run_frame("R10 stream ignores", IDLE, mkw(2, 0, 0, 8'h99), mkw(3, 1, 0, 8'h00), IDLE);
    run_frame("R11 escape", IDLE, 16'h0001, 16'h1234, IDLE);
    run_frame("R11 back to command", IDLE, mkw(1, 1, 0, 8'h00), mkw(2, 1, 0, 8'h00), IDLE);

    // R11 escape ignored without split format, R9 reset leaves stream mode
    run_frame("R11 enter plain", IDLE, mkw(1, 0, 0, 8'h40), IDLE, IDLE);
    run_frame("R11 no escape", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    run_frame("R11 still stream", IDLE, 16'h0001, 16'h0001, IDLE);
    do_reset();
    run_frame("R9 after reset", IDLE, mkw(1, 1, 0, 8'h00), mkw(6, 1, 0, 8'h00), IDLE);

    check("R12 sdout stable at rising edges", 32'(r12_bad), 32'h0);
    finish_run();
  end

endmodule